// File: doc/BRIEF.md
# Level-Sensitive Counting Interrupt Controller

This block merges a parameterized set of level-sensitive interrupt lines, 64 by default, into one request line for a processor. Each line passes through a two-flop synchronizer, and the block keeps a stored copy of its level. Each line also has its own enable bit. A counter holds how many lines are currently both high and enabled. The request output is raised whenever that counter is non-zero.

Software uses a 32-bit register port with valid, write, address and write data. Reads return data in the same cycle. The port can read a fixed identity word, the pending count and the lowest-numbered active line. It can enable or disable one line, with the line number given in the write data, and it can switch every line off at once. Only byte-address bits [11:2] select a word. Words 0 to 5 are defined, and any other word raises an error pulse.

Top module: `cnt_irq_ctrl`

## Requirements
- R1: After reset the pending count is 0, `irq_out` is low, every enable is clear and word 2 reads 32'hFFFFFFFF.
- R2: A read of word 0 returns 32'h1C0C_A001. A write to word 0 changes nothing.
- R3: A read of word 1 returns the number of lines whose stored level and enable are both 1.
- R4: A read of word 2 returns the smallest line number whose stored level and enable are both 1. If no line qualifies, it returns 32'hFFFFFFFF.
- R5: A write to word 3, whatever the data, clears every enable, so the count reads 0 afterwards.
- R6: A write to word 4 with data k < NUM_SRC clears enable k. The count drops by one if line k was enabled and its stored level was high.
- R7: A write to word 5 with data k < NUM_SRC sets enable k. The count rises by one if line k was disabled and its stored level was high.
- R8: A write to word 4 or word 5 with data of NUM_SRC or more changes no enable and no count.
- R9: A change on `irq_in[k]` reaches the stored level on the third rising edge after it. The change moves the count only when enable k is set.
- R10: `irq_out` is high exactly when the pending count is greater than zero.
- R11: When a level change and a register write take effect on the same edge, both are applied to the count. The result equals the number of lines that are high and enabled after that edge.
- R12: An access to a word above 5 reads 0 and changes no state. `access_err` is high for exactly the one cycle after such an access. Reads of words 3 to 5 return 0 without an error.
- R13: Address bits [31:12] and [1:0] do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Level-sensitive interrupt lines, asynchronous |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; only bits [11:2] are decoded |
| req_wdata | input | 32 | Write data (a line number for words 4 and 5) |
| rsp_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq_out | output | 1 | Request to the processor |
| access_err | output | 1 | One-cycle pulse after an access to an undefined word |

## Verification
Two paths can update the pending count on the same clock edge: a synchronized level change reaching the stored level, and an enable or disable write. The bench provokes this by changing a line and then, two cycles later, issuing an enable, a disable or a global disable for that same line. That write lands on the edge where the new level is stored. A randomized phase does the same thing without direction by mixing line toggles with writes. A behavioural model applies the level update first and then the write. After every edge, its count, its request output and its read values are compared with the design's.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned WSEL_W = 10;
    localparam logic [DATA_W-1:0] CIC_IDENT = 32'h1C0C_A001;
    localparam logic [DATA_W-1:0] NONE_ACTIVE = '1;

    typedef enum logic [WSEL_W-1:0] {
        WSEL_IDENT   = 10'd0,
        WSEL_PENDING = 10'd1,
        WSEL_LOWEST  = 10'd2,
        WSEL_ALL_OFF = 10'd3,
        WSEL_OFF     = 10'd4,
        WSEL_ON      = 10'd5
    } wsel_e;

    localparam logic [WSEL_W-1:0] WSEL_LAST = 10'd5;

endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1_d, s1_q, s2_d, s2_q;

        always_comb begin
            s1_d = async_in[g];
            s2_d = s1_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= s1_d;
                s2_q <= s2_d;
            end
        end

        assign sync_out[g] = s2_q;
    end

endmodule

// File: rtl/cic_decode.sv
module cic_decode
    import cic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned IDX_W   = 6
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [WSEL_W-1:0] wsel,
    output logic              rd_en,
    output logic              all_off,
    output logic              one_off,
    output logic              one_on,
    output logic [IDX_W-1:0]  idx,
    output logic              bad_word
);

    logic in_range;
    logic wr_en;

    always_comb begin
        wsel     = req_addr[11:2];
        wr_en    = req_valid && req_write;
        rd_en    = req_valid && !req_write;
        in_range = (req_wdata < DATA_W'(NUM_SRC));
        idx      = req_wdata[IDX_W-1:0];
        all_off  = wr_en && (wsel == WSEL_ALL_OFF);
        one_off  = wr_en && (wsel == WSEL_OFF) && in_range;
        one_on   = wr_en && (wsel == WSEL_ON) && in_range;
        bad_word = req_valid && (wsel > WSEL_LAST);
    end

endmodule

// File: rtl/cic_lowest.sv
module cic_lowest #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0] active,
    output logic               found,
    output logic [IDX_W-1:0]   index
);

    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                found = 1'b1;
                index = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cic_core.sv
module cic_core #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_in,
    input  logic               all_off,
    input  logic               one_off,
    input  logic               one_on,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] lvl_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [CNT_W-1:0]   cnt_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
        logic [NUM_SRC-1:0] en;
        logic [CNT_W-1:0]   cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [NUM_SRC-1:0] act_now, act_next, gained, lost;
    logic [CNT_W-1:0]   n_up, n_dn;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_in;

        if (all_off) begin
            st_d.en = '0;
        end else if (one_off) begin
            st_d.en[idx] = 1'b0;
        end else if (one_on) begin
            st_d.en[idx] = 1'b1;
        end

        act_now  = st_q.lvl & st_q.en;
        act_next = st_d.lvl & st_d.en;
        gained   = act_next & ~act_now;
        lost     = act_now & ~act_next;

        n_up = '0;
        n_dn = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            n_up = n_up + CNT_W'(gained[i]);
            n_dn = n_dn + CNT_W'(lost[i]);
        end

        if (all_off) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + n_up - n_dn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_q = st_q.lvl;
    assign en_q  = st_q.en;
    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/cnt_irq_ctrl.sv
module cnt_irq_ctrl
    import cic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [31:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic [31:0]        rsp_rdata,
    output logic               irq_out,
    output logic               access_err
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned CNT_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] lvl_sync, lvl_q, en_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [WSEL_W-1:0]  wsel;
    logic               rd_en, all_off, one_off, one_on, bad_word;
    logic [IDX_W-1:0]   idx, low_idx;
    logic               low_found;
    logic               err_d, err_q;

    cic_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (lvl_sync)
    );

    cic_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wsel      (wsel),
        .rd_en     (rd_en),
        .all_off   (all_off),
        .one_off   (one_off),
        .one_on    (one_on),
        .idx       (idx),
        .bad_word  (bad_word)
    );

    cic_core #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (lvl_sync),
        .all_off (all_off),
        .one_off (one_off),
        .one_on  (one_on),
        .idx     (idx),
        .lvl_q   (lvl_q),
        .en_q    (en_q),
        .cnt_q   (cnt_q)
    );

    cic_lowest #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_low (
        .active (lvl_q & en_q),
        .found  (low_found),
        .index  (low_idx)
    );

    always_comb begin
        rsp_rdata = '0;
        if (rd_en) begin
            case (wsel)
                WSEL_IDENT:   rsp_rdata = CIC_IDENT;
                WSEL_PENDING: rsp_rdata = DATA_W'(cnt_q);
                WSEL_LOWEST:  rsp_rdata = low_found ? DATA_W'(low_idx) : NONE_ACTIVE;
                default:      rsp_rdata = '0;
            endcase
        end
        err_d = bad_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign irq_out    = (cnt_q != '0);
    assign access_err = err_q;

endmodule

// File: rtl/cic_chk.sv
module cic_chk #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned CNT_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [31:0]        req_addr,
    input logic [31:0]        req_wdata,
    input logic [NUM_SRC-1:0] lvl_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [CNT_W-1:0]   cnt_q,
    input logic               irq_out,
    input logic               access_err
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    // R3
    count_tracks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) == $countones(lvl_q & en_q));

    // R10
    irq_vs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(lvl_q & en_q)));

    // R5
    all_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[11:2] == 10'd3)
        |=> (en_q == '0 && cnt_q == '0));

    // R7
    enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[11:2] == 10'd5 && req_wdata < 32'(NUM_SRC))
        |=> en_q[$past(req_wdata[IDX_W-1:0])]);

    // R8
    range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr[11:2] == 10'd4 || req_addr[11:2] == 10'd5)
         && req_wdata >= 32'(NUM_SRC))
        |=> $stable(en_q));

    // R12
    bad_word_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:2] > 10'd5) |=> access_err);

    // R12
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_addr[11:2] > 10'd5) |=> !access_err);

endmodule

bind cnt_irq_ctrl cic_chk #(
    .NUM_SRC (NUM_SRC),
    .CNT_W   ($clog2(NUM_SRC + 1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .lvl_q      (lvl_q),
    .en_q       (en_q),
    .cnt_q      (cnt_q),
    .irq_out    (irq_out),
    .access_err (access_err)
);

// File: tb/cnt_irq_ctrl_test.sv
module cnt_irq_ctrl_test;

    localparam int N = 64;
    localparam logic [31:0] IDENT = 32'h1C0C_A001;
    localparam logic [31:0] A_ID = 32'h0, A_PEND = 32'h4, A_LOW = 32'h8;
    localparam logic [31:0] A_ALLOFF = 32'hC, A_OFF = 32'h10, A_ON = 32'h14;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]   req_addr = '0, req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic          irq_out, access_err;

    cnt_irq_ctrl #(.NUM_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_out(irq_out), .access_err(access_err)
    );

    int total = 0, bad = 0;
    logic [N-1:0] irq_drv = '0;

    // behavioural reference model
    bit [N-1:0] m_s1 = '0, m_s2 = '0, m_lvl = '0, m_en = '0;
    int m_cnt = 0;
    bit m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_lvl = '0; m_en = '0; m_cnt = 0; m_err = 0;
        end else begin
            int w;
            int k;
            for (int i = 0; i < N; i++) begin
                if (m_s2[i] != m_lvl[i]) begin
                    m_lvl[i] = m_s2[i];
                    if (m_en[i]) m_cnt = m_lvl[i] ? m_cnt + 1 : m_cnt - 1;
                end
            end
            m_s2 = m_s1;
            m_s1 = irq_in;
            w = int'(req_addr[11:2]);
            k = int'(req_wdata[5:0]);
            if (req_valid && req_write) begin
                if (w == 3) begin
                    m_en = '0; m_cnt = 0;
                end else if (w == 4 && req_wdata < N) begin
                    if (m_en[k]) begin
                        if (m_lvl[k]) m_cnt--;
                        m_en[k] = 0;
                    end
                end else if (w == 5 && req_wdata < N) begin
                    if (!m_en[k]) begin
                        if (m_lvl[k]) m_cnt++;
                        m_en[k] = 1;
                    end
                end
            end
            m_err = req_valid && (w > 5);
        end
    end

    function automatic logic [31:0] m_read(logic [31:0] a);
        case (int'(a[11:2]))
            0: return IDENT;
            1: return 32'(m_cnt);
            2: begin
                for (int i = 0; i < N; i++) if (m_lvl[i] && m_en[i]) return 32'(i);
                return 32'hFFFF_FFFF;
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, bit w, logic [31:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        if (rst_n) begin
            check("R10 irq_out", {31'b0, irq_out}, {31'b0, m_cnt > 0});
            check("R12 access_err", {31'b0, access_err}, {31'b0, m_err});
        end
        irq_in = irq_drv;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        #1;
        if (v && !w) check(tag, rsp_rdata, m_read(a));
    endtask

    task automatic rd(logic [31:0] a, string tag);
        step(1, 0, a, 32'h0, tag);
    endtask
    task automatic wr(logic [31:0] a, logic [31:0] d);
        step(1, 1, a, d, "");
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 32'h0, 32'h0, "");
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq_out in reset", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state via the port
        rd(A_PEND, "R1 count after reset");
        check("R1 count value", rsp_rdata, 32'h0);
        rd(A_LOW, "R1 lowest after reset");
        check("R1 lowest none", rsp_rdata, 32'hFFFF_FFFF);
        // R2 identity, write ignored
        rd(A_ID, "R2 ident");
        wr(A_ID, 32'h1234_5678);
        rd(A_ID, "R2 ident after write");
        // R9 disabled line does not count
        irq_drv[5] = 1'b1;
        idle(4);
        rd(A_PEND, "R9 disabled line ignored");
        // R7 enable with level high
        wr(A_ON, 5);
        rd(A_PEND, "R7 enable counts");
        rd(A_LOW, "R4 lowest is 5");
        // R8 out of range
        wr(A_ON, 64);
        wr(A_ON, 32'h8000_0003);
        wr(A_OFF, 100);
        rd(A_PEND, "R8 out of range ignored");
        // R7 enable while low, then R9 rise
        wr(A_ON, 3);
        rd(A_PEND, "R7 enable with low level");
        irq_drv[3] = 1'b1;
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        rd(A_PEND, "R9 latency before third edge");
        rd(A_PEND, "R9 count after rise");
        rd(A_LOW, "R4 lowest is 3");
        // R13 aliases
        rd(32'h0000_1004, "R13 alias pending");
        rd(32'hABCD_E00B, "R13 alias lowest");
        // R6 disable through alias
        wr(32'h0000_2013, 3);
        rd(A_PEND, "R6 disable drops count");
        rd(A_LOW, "R4 lowest back to 5");
        // R11 enable on same edge as rise
        irq_drv[10] = 1'b1;
        idle(2);
        wr(A_ON, 10);
        rd(A_PEND, "R11 enable with same-edge rise");
        // R11 disable on same edge as fall
        irq_drv[5] = 1'b0;
        idle(2);
        wr(A_OFF, 5);
        rd(A_PEND, "R11 disable with same-edge fall");
        // R11 global off on same edge as a rise of an enabled line
        wr(A_ON, 20);
        irq_drv[20] = 1'b1;
        idle(2);
        wr(A_ALLOFF, 32'h0);
        rd(A_PEND, "R11 all-off with same-edge rise");
        rd(A_LOW, "R5 lowest none after all-off");
        // R12 undefined words
        wr(A_ON, 10);
        rd(32'h0000_001C, "R12 undefined read zero");
        wr(32'h0000_0024, 10);
        rd(A_PEND, "R12 undefined write ignored");
        rd(A_OFF, "R12 write-only word reads zero");
        // randomized mix
        for (int c = 0; c < 600; c++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) irq_drv[$urandom_range(0, N - 1)] ^= 1'b1;
            case (op)
                0, 1: wr(A_ON, $urandom_range(0, N + 3));
                2:    wr(A_OFF, $urandom_range(0, N + 3));
                3:    rd(A_PEND, "R3 random pending");
                4:    rd(A_LOW, "R4 random lowest");
                5:    if (c % 50 == 0) wr(A_ALLOFF, 0); else idle(1);
                6:    rd(32'h0000_0040, "R12 random undefined");
                default: idle(1);
            endcase
        end
        wr(A_ALLOFF, 32'hFFFF_FFFF);
        rd(A_PEND, "R5 count zero after all-off");
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule